// File: doc/BRIEF.md
# Power Source Selector Controller

This block decides whether a system load draws from a wall adapter or from a battery, and drives one active-low enable for each of the two power switches. All of its inputs are digital flags that arrive asynchronously: adapter present, battery depleted, battery absent, system rail above battery, a host request for adapter power, and a charge enable. Every flag passes through a multi-flop synchronizer before any decision is made. The controller never closes both switches together. Each changeover opens the conducting switch first, then waits a number of clock cycles set by a parameter before closing the other one.

The host normally picks the source. The controller overrides that choice when the adapter disappears, when no battery is fitted, and, in the alternate variant, when the battery is depleted while the adapter is present. An alarm output reports a depleted battery. In the default variant it also reports any case where the granted source differs from the one the host asked for. A charge-run output lets the charger's modulator run only while the adapter switch conducts and both the host request and the charge enable are high. When that output is low, the modulator's gate drive is parked off.

Top module: `pwr_src_sel`

## Requirements
- R1: During reset both switch enables are high (open), and alarm, charge-run and adapter-present status are low. After reset release both switches stay open until the first dead time has elapsed.
- R2: Every input flag passes through a two-flop synchronizer. A flag change shows on the adapter-present status at the second rising edge after the change. A change of switch state follows at the third rising edge.
- R3: While the synchronized adapter-present flag is low, the adapter switch is open from the following edge, charge-run is low, and the battery switch is granted.
- R4: With the adapter present, the host request high grants the adapter and the host request low grants the battery.
- R5: With the adapter present and the battery-absent flag high, the adapter is granted whatever the host request is.
- R6: The two switch enables are never low together. The battery switch closes only after at least DT_A2B_CYC consecutive cycles with both switches open. The adapter switch closes only after at least DT_B2A_CYC such cycles.
- R7: While the synchronized system-above-battery flag is high, the battery switch is open from the following edge. It closes again once the flag is low and the battery is still granted.
- R8: The alarm is high whenever the synchronized depleted flag is high, regardless of the granted source.
- R9: In the default variant (ALT_DEPLETE_TO_ADP = 0) the alarm is also high whenever the granted source differs from the host request (request high = adapter). A depleted battery alone does not change the granted source.
- R10: In the alternate variant (ALT_DEPLETE_TO_ADP = 1) a depleted battery with the adapter present grants the adapter, and a request/grant mismatch does not raise the alarm.
- R11: Charge-run is high only while the adapter switch is closed and the adapter-present, host-request and charge-enable flags are all high.
- R12: If the adapter is lost while the host requests it, the controller moves to the battery with the alarm high. When the adapter returns with the request still high, it moves back to the adapter and the alarm clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adp_present_i | input | 1 | Adapter present flag (asynchronous) |
| bat_low_i | input | 1 | Battery depleted flag (asynchronous) |
| bat_absent_i | input | 1 | No battery flag (asynchronous) |
| vsys_above_i | input | 1 | System rail above battery flag (asynchronous) |
| host_sel_adp_i | input | 1 | Host request: 1 = adapter, 0 = battery |
| chg_enable_i | input | 1 | Charge enable |
| adp_sw_n_o | output | 1 | Adapter switch enable, active low |
| bat_sw_n_o | output | 1 | Battery switch enable, active low |
| adp_present_o | output | 1 | Synchronized adapter-present status |
| alarm_o | output | 1 | Depletion / source mismatch alarm |
| chg_run_o | output | 1 | Charger modulator run enable |

## Verification
The bench targets changeovers. Each one is timed exactly from the input edge through the synchronizer to the closing switch. A short dead time, or an off-by-one in the gap counter, would let one switch close a cycle early, and in the worst case both would conduct together. The host request is flipped again while a gap is still running. A sequencer that reloaded its count or skipped the gap there would close the wrong switch too soon. The bench raises the system-above-battery flag while the battery is granted, which a missing interlock would ignore. It also compares both variants side by side under depletion and no-battery conditions. A swapped variant would then show up as the wrong switch closed or a spurious alarm.

// File: rtl/pwr_src_pkg.sv
package pwr_src_pkg;

    typedef enum logic [1:0] {
        SRC_GAP = 2'd0,
        SRC_ADP = 2'd1,
        SRC_BAT = 2'd2
    } src_state_e;

    typedef struct packed {
        logic chg_en;
        logic host_adp;
        logic vsys_hi;
        logic no_bat;
        logic bat_low;
        logic adp_ok;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    // Granted source: adapter only when it is present and something asks for it.
    function automatic logic grant_to_adp(flags_t f, logic alt_deplete);
        return f.adp_ok && (f.host_adp || f.no_bat || (alt_deplete && f.bat_low));
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_src_policy.sv
module pwr_src_policy
    import pwr_src_pkg::*;
#(
    parameter bit ALT_DEPLETE = 1'b0
) (
    input  flags_t     f,
    input  src_state_e st,
    output logic       want_adp,
    output logic       alarm,
    output logic       chg_run
);
    logic mismatch;

    always_comb begin
        want_adp = grant_to_adp(f, ALT_DEPLETE);
        mismatch = (f.host_adp != want_adp);
        chg_run  = (st == SRC_ADP) && f.adp_ok && f.host_adp && f.chg_en;
    end

    if (ALT_DEPLETE) begin : g_alt
        assign alarm = f.bat_low;
    end else begin : g_dflt
        assign alarm = f.bat_low || mismatch;
    end
endmodule

// File: rtl/pwr_src_seq.sv
module pwr_src_seq
    import pwr_src_pkg::*;
#(
    parameter int DT_A2B = 250,
    parameter int DT_B2A = 450
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       want_adp,
    input  logic       bat_block,
    output src_state_e state
);
    localparam int CMAX = imax(DT_A2B, DT_B2A);
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] LIM_BAT = CW'(DT_A2B - 1);
    localparam logic [CW-1:0] LIM_ADP = CW'(DT_B2A - 1);
    localparam logic [CW-1:0] CAP     = CW'(CMAX);

    src_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SRC_ADP: begin
                if (!want_adp) begin
                    st_d  = SRC_GAP;
                    cnt_d = '0;
                end
            end
            SRC_BAT: begin
                if (want_adp || bat_block) begin
                    st_d  = SRC_GAP;
                    cnt_d = '0;
                end
            end
            default: begin
                if (want_adp && cnt_q >= LIM_ADP)
                    st_d = SRC_ADP;
                else if (!want_adp && !bat_block && cnt_q >= LIM_BAT)
                    st_d = SRC_BAT;
                else if (cnt_q != CAP)
                    cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SRC_GAP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/pwr_src_sel.sv
module pwr_src_sel
    import pwr_src_pkg::*;
#(
    parameter bit ALT_DEPLETE_TO_ADP = 1'b0,
    parameter int DT_A2B_CYC         = 250,
    parameter int DT_B2A_CYC         = 450,
    parameter int SYNC_STAGES        = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adp_present_i,
    input  logic bat_low_i,
    input  logic bat_absent_i,
    input  logic vsys_above_i,
    input  logic host_sel_adp_i,
    input  logic chg_enable_i,
    output logic adp_sw_n_o,
    output logic bat_sw_n_o,
    output logic adp_present_o,
    output logic alarm_o,
    output logic chg_run_o
);
    flags_t     flags_raw, flags_s;
    src_state_e st;
    logic       want_adp;

    assign flags_raw = {chg_enable_i, host_sel_adp_i, vsys_above_i,
                        bat_absent_i, bat_low_i, adp_present_i};

    pwr_flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flags_raw),
        .q   (flags_s)
    );

    pwr_src_policy #(.ALT_DEPLETE(ALT_DEPLETE_TO_ADP)) u_policy (
        .f        (flags_s),
        .st       (st),
        .want_adp (want_adp),
        .alarm    (alarm_o),
        .chg_run  (chg_run_o)
    );

    pwr_src_seq #(.DT_A2B(DT_A2B_CYC), .DT_B2A(DT_B2A_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .want_adp  (want_adp),
        .bat_block (flags_s.vsys_hi),
        .state     (st)
    );

    assign adp_sw_n_o    = (st != SRC_ADP);
    assign bat_sw_n_o    = (st != SRC_BAT);
    assign adp_present_o = flags_s.adp_ok;
endmodule

// File: rtl/pwr_src_sel_chk.sv
module pwr_src_sel_chk
    import pwr_src_pkg::*;
#(
    parameter int DT_A2B = 250,
    parameter int DT_B2A = 450
) (
    input logic   clk,
    input logic   rst,
    input flags_t f,
    input logic   adp_sw_n,
    input logic   bat_sw_n,
    input logic   chg_run
);
    int off_run;

    always_ff @(posedge clk) begin
        if (rst)                               off_run <= 0;
        else if (adp_sw_n && bat_sw_n) begin
            if (off_run < 32'h3fff_ffff)       off_run <= off_run + 1;
        end else                               off_run <= 0;
    end

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        adp_sw_n || bat_sw_n);

    // R6
    bat_dead_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bat_sw_n) |-> off_run >= DT_A2B);

    // R6
    adp_dead_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(adp_sw_n) |-> off_run >= DT_B2A);

    // R7
    vsys_interlock_chk: assert property (@(posedge clk) disable iff (rst)
        f.vsys_hi |=> bat_sw_n);

    // R3
    adp_absent_open_chk: assert property (@(posedge clk) disable iff (rst)
        !f.adp_ok |=> adp_sw_n);

    // R11
    chg_on_adapter_chk: assert property (@(posedge clk) disable iff (rst)
        chg_run |-> (!adp_sw_n && bat_sw_n));
endmodule

bind pwr_src_sel pwr_src_sel_chk #(
    .DT_A2B (DT_A2B_CYC),
    .DT_B2A (DT_B2A_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .f        (flags_s),
    .adp_sw_n (adp_sw_n_o),
    .bat_sw_n (bat_sw_n_o),
    .chg_run  (chg_run_o)
);

// File: tb/pwr_src_sel_test.sv
`timescale 1ns/1ps
module pwr_src_sel_test;
    localparam int DA = 6;   // adapter -> battery gap
    localparam int DB = 9;   // battery -> adapter gap
    localparam int SETTLE = 25;

    // stimulus bits: 0 adapter, 1 depleted, 2 no battery, 3 vsys high, 4 host adp, 5 charge en
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] fin = '0;
    logic [1:0] o_adp_n, o_bat_n, o_ok, o_alarm, o_chg;
    int  checks = 0, fails = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    pwr_src_sel #(.ALT_DEPLETE_TO_ADP(1'b0), .DT_A2B_CYC(DA), .DT_B2A_CYC(DB)) uut (
        .clk(clk), .rst(rst),
        .adp_present_i(fin[0]), .bat_low_i(fin[1]), .bat_absent_i(fin[2]),
        .vsys_above_i(fin[3]), .host_sel_adp_i(fin[4]), .chg_enable_i(fin[5]),
        .adp_sw_n_o(o_adp_n[0]), .bat_sw_n_o(o_bat_n[0]), .adp_present_o(o_ok[0]),
        .alarm_o(o_alarm[0]), .chg_run_o(o_chg[0]));

    pwr_src_sel #(.ALT_DEPLETE_TO_ADP(1'b1), .DT_A2B_CYC(DA), .DT_B2A_CYC(DB)) uut_alt (
        .clk(clk), .rst(rst),
        .adp_present_i(fin[0]), .bat_low_i(fin[1]), .bat_absent_i(fin[2]),
        .vsys_above_i(fin[3]), .host_sel_adp_i(fin[4]), .chg_enable_i(fin[5]),
        .adp_sw_n_o(o_adp_n[1]), .bat_sw_n_o(o_bat_n[1]), .adp_present_o(o_ok[1]),
        .alarm_o(o_alarm[1]), .chg_run_o(o_chg[1]));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    // m_st: 0 both open, 1 adapter closed, 2 battery closed
    bit [5:0] m_s1[2], m_s2[2];
    int       m_st[2], m_gap[2];
    bit       m_ok = 0;

    function automatic int m_grant(int v, bit [5:0] f);
        if (f[0] && (f[4] || f[2] || (v == 1 && f[1]))) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            int g;
            if (rst) begin
                m_s1[v] = '0; m_s2[v] = '0; m_st[v] = 0; m_gap[v] = 0;
            end else begin
                g = m_grant(v, m_s2[v]);
                if (m_st[v] == 1) begin
                    if (g != 1) begin m_st[v] = 0; m_gap[v] = 0; end
                end else if (m_st[v] == 2) begin
                    if (g != 2 || m_s2[v][3]) begin m_st[v] = 0; m_gap[v] = 0; end
                end else begin
                    if (g == 1 && m_gap[v] + 1 >= DB)                      m_st[v] = 1;
                    else if (g == 2 && !m_s2[v][3] && m_gap[v] + 1 >= DA)  m_st[v] = 2;
                    else                                                    m_gap[v]++;
                end
                m_s2[v] = m_s1[v];
                m_s1[v] = fin;
            end
        end
        if (rst) m_ok = 1;
    end

    // cycle compare and independent gap monitor
    int offc[2] = '{0, 0};
    always @(negedge clk) begin
        if (m_ok && !done) begin
            for (int v = 0; v < 2; v++) begin
                int g, req, exp_alarm;
                g   = m_grant(v, m_s2[v]);
                req = m_s2[v][4] ? 1 : 2;
                exp_alarm = (m_s2[v][1] || (v == 0 && req != g)) ? 1 : 0;
                chk("R4 adapter switch vs model", o_adp_n[v], (m_st[v] != 1));
                chk("R4 battery switch vs model", o_bat_n[v], (m_st[v] != 2));
                chk("R2 adapter status vs model", o_ok[v], m_s2[v][0]);
                chk("R9 alarm vs model", o_alarm[v], exp_alarm);
                chk("R11 charge run vs model", o_chg[v],
                    (m_st[v] == 1 && m_s2[v][0] && m_s2[v][4] && m_s2[v][5]));
                chk("R6 no overlap", (!o_adp_n[v] && !o_bat_n[v]), 0);
                if (o_adp_n[v] && o_bat_n[v]) offc[v]++;
                else begin
                    if (offc[v] > 0 && !o_adp_n[v]) chk("R6 gap before adapter", offc[v] >= DB, 1);
                    if (offc[v] > 0 && !o_bat_n[v]) chk("R6 gap before battery", offc[v] >= DA, 1);
                    offc[v] = 0;
                end
            end
        end
    end

    task automatic drive(logic [5:0] val);
        @(negedge clk);
        fin = val;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        // R1: reset state
        waitn(4);
        for (int v = 0; v < 2; v++) begin
            chk("R1 reset adapter open", o_adp_n[v], 1);
            chk("R1 reset battery open", o_bat_n[v], 1);
            chk("R1 reset alarm", o_alarm[v], 0);
            chk("R1 reset charge", o_chg[v], 0);
            chk("R1 reset status", o_ok[v], 0);
        end
        rst = 1'b0;
        waitn(2);
        chk("R1 open after release", o_adp_n[0] && o_bat_n[0], 1);

        // R3: no adapter -> battery
        waitn(SETTLE);
        chk("R3 battery on", o_bat_n[0], 0);
        chk("R3 adapter off", o_adp_n[0], 1);
        chk("R3 no charge", o_chg[0], 0);

        // R6 exact gap battery -> adapter, R4, R11
        drive(6'b110001);
        waitn(3 + DB - 1);
        chk("R6 adapter still open", o_adp_n[0], 1);
        chk("R6 battery open in gap", o_bat_n[0], 1);
        waitn(1);
        chk("R6 adapter closes after gap", o_adp_n[0], 0);
        waitn(2);
        chk("R11 charge running", o_chg[0], 1);
        chk("R4 adapter granted", o_adp_n[1], 0);

        // R2 + R12: adapter loss with request high
        drive(6'b110000);
        waitn(1);
        chk("R2 status not yet", o_ok[0], 1);
        waitn(1);
        chk("R2 status after two edges", o_ok[0], 0);
        chk("R2 switch unchanged yet", o_adp_n[0], 0);
        chk("R12 alarm on loss", o_alarm[0], 1);
        chk("R10 alt no mismatch alarm", o_alarm[1], 0);
        waitn(1);
        chk("R2 switch opens third edge", o_adp_n[0], 1);
        waitn(SETTLE);
        chk("R12 battery after loss", o_bat_n[0], 0);
        chk("R12 alarm held", o_alarm[0], 1);
        drive(6'b110001);
        waitn(SETTLE);
        chk("R12 adapter restored", o_adp_n[0], 0);
        chk("R12 alarm cleared", o_alarm[0], 0);

        // R11: charge enable low
        drive(6'b010001);
        waitn(5);
        chk("R11 charge off when disabled", o_chg[0], 0);
        chk("R11 adapter kept", o_adp_n[0], 0);

        // R4: request battery
        drive(6'b000001);
        waitn(SETTLE);
        chk("R4 battery granted", o_bat_n[0], 0);
        chk("R4 alt battery granted", o_bat_n[1], 0);
        chk("R4 no alarm", o_alarm[0], 0);

        // R5: no battery forces adapter
        drive(6'b000101);
        waitn(SETTLE);
        chk("R5 adapter forced", o_adp_n[0], 0);
        chk("R5 alt adapter forced", o_adp_n[1], 0);
        chk("R9 mismatch alarm", o_alarm[0], 1);
        chk("R10 alt no mismatch alarm", o_alarm[1], 0);
        chk("R11 no charge with request low", o_chg[0], 0);

        // R8 / R10: depleted battery, request battery
        drive(6'b000011);
        waitn(SETTLE);
        chk("R9 default stays battery", o_bat_n[0], 0);
        chk("R8 alarm default", o_alarm[0], 1);
        chk("R10 alt returns to adapter", o_adp_n[1], 0);
        chk("R8 alarm alt", o_alarm[1], 1);

        // R7: vsys interlock
        drive(6'b001001);
        waitn(SETTLE);
        chk("R7 battery held open", o_bat_n[0], 1);
        chk("R7 adapter open too", o_adp_n[0], 1);
        drive(6'b000001);
        waitn(SETTLE);
        chk("R7 battery closes after release", o_bat_n[0], 0);

        // R8: depleted with no adapter
        drive(6'b000010);
        waitn(SETTLE);
        chk("R8 alarm on battery only", o_alarm[0], 1);
        chk("R3 battery in sleep", o_bat_n[0], 0);

        // R6: request flips back during a gap
        drive(6'b000001);
        waitn(SETTLE);
        drive(6'b110001);
        waitn(5);
        drive(6'b000001);
        waitn(4);
        drive(6'b110001);
        waitn(SETTLE + DB);
        chk("R6 adapter after flips", o_adp_n[0], 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1;
            summary();
            $finish;
        end
    end
endmodule